// File: doc/BRIEF.md
# One-Bit Predicated Logic Processor

This block is a bit-serial controller core. Each clock it accepts at most one operand-less 4-bit instruction from a sequential stream. The instruction can combine a single accumulator bit with an input line, pulse an output line, move the I/O selector, or arm a skip of the following instruction. Programs have no jumps. All conditional behaviour comes from predication: a skip instruction drops the next instruction when a stored SKIP flag is set.

I/O uses unary addressing. Eight opcodes each select one port, and logic and output opcodes act on whichever port is currently selected. The two lowest ports are not wired to the outside. They are stored flag bits: port 1 is SKIP and port 2 is HALT. A program can write them like outputs and read them like inputs, and the surrounding logic can also write them directly. For skip and halt decisions a new flag value is seen one instruction slot late. As readable data it is seen at once. A pass-end strobe from the program sequencer samples HALT and stops execution.

Top module: `bitlogic_core`

## Requirements
- R1: While reset is asserted, and after it is released, the accumulator and both flags read 0, no port is selected, every output pulse line is 0 and `halted` is 0. With no port selected, the input to logic and load operations is 0 and OUT drives no pulse.
- R2: Codes 8 to 15 select port 1 to 8 (port n = code − 7) and deselect every other port, so at most one port is selected at any time.
- R3: Code 1 XORs, code 3 ANDs and code 5 ORs the accumulator with the selected input. Code 4 loads the selected input. Code 7 inverts the accumulator. Each result is available to the very next instruction.
- R4: Code 6 (OUT) with accumulator 1 drives a pulse of exactly one cycle on `port_out[n-1]` of the selected port n, in the cycle after the instruction is accepted. With accumulator 0 no pulse appears. `port_out` never has more than one bit set.
- R5: Port 1 (`flag_q[0]`, SKIP) and port 2 (`flag_q[1]`, HALT) are stored bits. OUT copies the accumulator into the selected flag, including a 0. Loads and logic operations read the stored flag, not `port_in[0]` or `port_in[1]`, and they see a flag written by the instruction just before.
- R6: `flag_wr[i]` writes `flag_wdata[i]` into flag i on the next edge. It takes priority over an OUT to the same flag in the same cycle.
- R7: Code 2 (SKZ) with effective SKIP = 1 discards the next accepted instruction, which then changes no register, flag, selection or output. Only that one instruction is discarded. With effective SKIP = 0, SKZ does nothing.
- R8: The effective SKIP and HALT values follow the stored flags with a lag of one instruction slot. A flag written during slot k is used for skip or halt decisions from slot k+2 onward. Cycles without a valid instruction do not advance the lag.
- R9: A `pass_end` strobe while effective HALT is 1 sets `halted` on the next edge. `halted` stays set until reset, and while it is set every instruction is ignored.
- R10: A cycle with `instr_valid` low changes no state. Code 0 occupies a slot but has no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| instr_valid | input | 1 | An instruction is presented this cycle |
| instr_code | input | 4 | Instruction code |
| port_in | input | 8 | External input lines; bits 0 and 1 are unused because those ports are flags |
| flag_wr | input | 2 | External write strobe per flag (bit 0 SKIP, bit 1 HALT) |
| flag_wdata | input | 2 | Value for an external flag write |
| pass_end | input | 1 | Strobe marking the end of a program pass |
| port_out | output | 8 | Registered one-cycle output pulses, one line per port |
| flag_q | output | 2 | Stored flag values (bit 0 SKIP, bit 1 HALT) |
| halted | output | 1 | Execution has stopped |

## Verification
The bench builds the core with its default parameters: eight ports, two of them flags, and a 4-bit code. With these values every opcode is used, including all eight select codes. Both flag ports and six ordinary ports can be reached. The one-slot decision lag on SKIP and HALT can be observed directly against the immediate scratch read of the same flags. A directed phase covers each corner case. A long stream of random codes, input lines and external flag writes then checks skip chains, back-to-back OUT pulses and the interaction between external and program flag writes against a reference model.

// File: rtl/lp1_pkg.sv
package lp1_pkg;
  localparam int OPW   = 4;
  localparam int NPORT = 2 ** (OPW - 1);
  localparam int PW    = $clog2(NPORT);
  localparam int NFLAG = 2;
  localparam int SKIP_IDX = 0;
  localparam int HALT_IDX = 1;

  typedef enum logic [OPW-1:0] {
    OP_NONE = 4'd0,
    OP_XOR  = 4'd1,
    OP_SKZ  = 4'd2,
    OP_AND  = 4'd3,
    OP_LD   = 4'd4,
    OP_OR   = 4'd5,
    OP_OUT  = 4'd6,
    OP_NOT  = 4'd7
  } op_e;

  typedef struct packed {
    logic          op_xor;
    logic          op_and;
    logic          op_or;
    logic          op_ld;
    logic          op_not;
    logic          op_out;
    logic          op_skz;
    logic          op_sel;
    logic [PW-1:0] port;
  } dec_t;
endpackage

// File: rtl/lp1_decode.sv
module lp1_decode
  import lp1_pkg::*;
(
  input  logic [OPW-1:0] code,
  output dec_t           dec
);
  logic lo_half;

  always_comb begin
    lo_half    = ~code[OPW-1];
    dec.op_xor = lo_half & (code == OP_XOR);
    dec.op_skz = lo_half & (code == OP_SKZ);
    dec.op_and = lo_half & (code == OP_AND);
    dec.op_ld  = lo_half & (code == OP_LD);
    dec.op_or  = lo_half & (code == OP_OR);
    dec.op_out = lo_half & (code == OP_OUT);
    dec.op_not = lo_half & (code == OP_NOT);
    dec.op_sel = code[OPW-1];
    dec.port   = code[PW-1:0];
  end
endmodule

// File: rtl/lp1_port_bank.sv
module lp1_port_bank
  import lp1_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             slot,
  input  logic             fire,
  input  dec_t             dec,
  input  logic             acc,
  input  logic [NPORT-1:0] port_in,
  input  logic [NFLAG-1:0] ext_wr,
  input  logic [NFLAG-1:0] ext_wdata,
  output logic             sel_in,
  output logic [NPORT-1:0] pulse_q,
  output logic [NFLAG-1:0] flag_q,
  output logic [NFLAG-1:0] eff_q
);
  logic [NPORT-1:0] sel_q, sel_d;
  logic             sel_en;
  logic [NPORT-1:0] pulse_d;
  logic [NPORT-1:0] rd_vec;
  logic             out_fire;

  assign out_fire = fire & dec.op_out;

  // port selector: one-hot, replaced wholesale by a select opcode
  always_comb begin
    sel_en = fire & dec.op_sel;
    sel_d  = NPORT'(1) << dec.port;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     sel_q <= '0;
    else if (sel_en) sel_q <= sel_d;
  end

  // output pulses: registered, cleared every cycle unless OUT fires
  always_comb begin
    pulse_d = '0;
    if (out_fire) pulse_d = sel_q & {NPORT{acc}};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) pulse_q <= '0;
    else         pulse_q <= pulse_d;
  end

  // flag ports: stored bit plus lagged copy used for decisions
  for (genvar f = 0; f < NFLAG; f++) begin : g_flag
    logic flag_d, flag_en, eff_en;

    always_comb begin
      flag_en = ext_wr[f] | (out_fire & sel_q[f]);
      flag_d  = ext_wr[f] ? ext_wdata[f] : acc;
      eff_en  = slot;
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)      flag_q[f] <= 1'b0;
      else if (flag_en) flag_q[f] <= flag_d;
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)     eff_q[f] <= 1'b0;
      else if (eff_en) eff_q[f] <= flag_q[f];
    end
  end

  // read vector: flag ports read their stored bit, others the pins
  for (genvar g = 0; g < NPORT; g++) begin : g_rd
    if (g < NFLAG) begin : g_is_flag
      assign rd_vec[g] = flag_q[g];
    end else begin : g_is_pin
      assign rd_vec[g] = port_in[g];
    end
  end

  assign sel_in = |(sel_q & rd_vec);
endmodule

// File: rtl/lp1_exec.sv
module lp1_exec
  import lp1_pkg::*;
(
  input  logic clk,
  input  logic rst_ni,
  input  logic instr_valid,
  input  dec_t dec,
  input  logic sel_in,
  input  logic skip_eff,
  input  logic halt_eff,
  input  logic pass_end,
  output logic slot,
  output logic fire,
  output logic acc_q,
  output logic halted_q
);
  logic acc_d, acc_en;
  logic pend_q, pend_d;
  logic halted_d;

  assign slot = instr_valid & ~halted_q;
  assign fire = slot & ~pend_q;

  // accumulator next state
  always_comb begin
    acc_d  = acc_q;
    acc_en = fire & (dec.op_xor | dec.op_and | dec.op_or | dec.op_ld | dec.op_not);
    if (dec.op_xor) acc_d = acc_q ^ sel_in;
    if (dec.op_and) acc_d = acc_q & sel_in;
    if (dec.op_or)  acc_d = acc_q | sel_in;
    if (dec.op_ld)  acc_d = sel_in;
    if (dec.op_not) acc_d = ~acc_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= 1'b0;
    else if (acc_en) acc_q <= acc_d;
  end

  // skip latch: armed by SKZ, consumed by the next slot
  always_comb pend_d = fire & dec.op_skz & skip_eff;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)   pend_q <= 1'b0;
    else if (slot) pend_q <= pend_d;
  end

  // halt: sampled at pass end, sticky
  always_comb halted_d = halted_q | (pass_end & halt_eff);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) halted_q <= 1'b0;
    else         halted_q <= halted_d;
  end
endmodule

// File: rtl/bitlogic_core.sv
module bitlogic_core
  import lp1_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             instr_valid,
  input  logic [OPW-1:0]   instr_code,
  input  logic [NPORT-1:0] port_in,
  input  logic [NFLAG-1:0] flag_wr,
  input  logic [NFLAG-1:0] flag_wdata,
  input  logic             pass_end,
  output logic [NPORT-1:0] port_out,
  output logic [NFLAG-1:0] flag_q,
  output logic             halted
);
  logic [1:0]       rst_sync_q;
  logic             rst_core_n;
  dec_t             dec;
  logic             slot, fire, acc, sel_in;
  logic [NFLAG-1:0] eff;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  lp1_decode u_dec (
    .code (instr_code),
    .dec  (dec)
  );

  lp1_port_bank u_bank (
    .clk       (clk),
    .rst_ni    (rst_core_n),
    .slot      (slot),
    .fire      (fire),
    .dec       (dec),
    .acc       (acc),
    .port_in   (port_in),
    .ext_wr    (flag_wr),
    .ext_wdata (flag_wdata),
    .sel_in    (sel_in),
    .pulse_q   (port_out),
    .flag_q    (flag_q),
    .eff_q     (eff)
  );

  lp1_exec u_exec (
    .clk         (clk),
    .rst_ni      (rst_core_n),
    .instr_valid (instr_valid),
    .dec         (dec),
    .sel_in      (sel_in),
    .skip_eff    (eff[SKIP_IDX]),
    .halt_eff    (eff[HALT_IDX]),
    .pass_end    (pass_end),
    .slot        (slot),
    .fire        (fire),
    .acc_q       (acc),
    .halted_q    (halted)
  );
endmodule

// File: rtl/lp1_checker.sv
module lp1_checker
  import lp1_pkg::*;
(
  input logic             clk,
  input logic             rst_ni,
  input logic             instr_valid,
  input logic [OPW-1:0]   instr_code,
  input logic [NFLAG-1:0] flag_wr,
  input logic [NFLAG-1:0] flag_wdata,
  input logic [NPORT-1:0] port_out,
  input logic [NFLAG-1:0] flag_q,
  input logic             halted
);
  assert_pulse_onehot_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(port_out));

  assert_pulse_from_out_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (instr_code != OP_OUT || !instr_valid) |=> (port_out == '0));

  assert_ext_skip_wr_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    flag_wr[SKIP_IDX] |=> (flag_q[SKIP_IDX] == $past(flag_wdata[SKIP_IDX])));

  assert_ext_halt_wr_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    flag_wr[HALT_IDX] |=> (flag_q[HALT_IDX] == $past(flag_wdata[HALT_IDX])));

  assert_idle_flags_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (!instr_valid && flag_wr == '0) |=> $stable(flag_q));

  assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    halted |=> halted);

  assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    halted |=> (port_out == '0));
endmodule

bind bitlogic_core lp1_checker u_chk (
  .clk         (clk),
  .rst_ni      (rst_core_n),
  .instr_valid (instr_valid),
  .instr_code  (instr_code),
  .flag_wr     (flag_wr),
  .flag_wdata  (flag_wdata),
  .port_out    (port_out),
  .flag_q      (flag_q),
  .halted      (halted)
);

// File: tb/bitlogic_core_tb.sv
module bitlogic_core_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       instr_valid;
  logic [3:0] instr_code;
  logic [7:0] port_in;
  logic [1:0] flag_wr;
  logic [1:0] flag_wdata;
  logic       pass_end;
  logic [7:0] port_out;
  logic [1:0] flag_q;
  logic       halted;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [10:0] exp_q[$];
  string       req_q[$];

  // reference model state
  logic m_acc, m_skip, m_halt, m_seff, m_heff, m_pend, m_halted;
  int   m_sel;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitlogic_core u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr_code  (instr_code),
    .port_in     (port_in),
    .flag_wr     (flag_wr),
    .flag_wdata  (flag_wdata),
    .pass_end    (pass_end),
    .port_out    (port_out),
    .flag_q      (flag_q),
    .halted      (halted)
  );

  task automatic model_reset();
    m_acc = 0; m_skip = 0; m_halt = 0; m_seff = 0; m_heff = 0;
    m_pend = 0; m_halted = 0; m_sel = -1;
  endtask

  task automatic check_now(input logic [10:0] exp, input string req);
    logic [10:0] act;
    act = {halted, flag_q, port_out};
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // monitor: compares registered outputs half a cycle after each edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [10:0] e;
      string       r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      check_now(e, r);
    end
  end

  // driver: applies one cycle of stimulus and pushes the expectation
  task automatic step(input logic v, input logic [3:0] code, input logic [7:0] pin,
                      input logic [1:0] ewr, input logic [1:0] ewd, input logic pe,
                      input string req);
    logic [7:0] pulse;
    logic       inb, o_skip, o_halt, o_heff;
    @(negedge clk);
    instr_valid = v; instr_code = code; port_in = pin;
    flag_wr = ewr; flag_wdata = ewd; pass_end = pe;
    pulse = '0;
    o_skip = m_skip; o_halt = m_halt; o_heff = m_heff;
    if (v && !m_halted) begin
      if (m_pend) begin
        m_pend = 0;
      end else begin
        if (m_sel < 0)       inb = 0;
        else if (m_sel == 0) inb = m_skip;
        else if (m_sel == 1) inb = m_halt;
        else                 inb = pin[m_sel];
        case (code)
          4'd1: m_acc = m_acc ^ inb;
          4'd2: m_pend = m_seff;
          4'd3: m_acc = m_acc & inb;
          4'd4: m_acc = inb;
          4'd5: m_acc = m_acc | inb;
          4'd6: if (m_sel >= 0) begin
                  pulse[m_sel] = m_acc;
                  if (m_sel == 0) m_skip = m_acc;
                  if (m_sel == 1) m_halt = m_acc;
                end
          4'd7: m_acc = ~m_acc;
          default: if (code >= 4'd8) m_sel = int'(code) - 8;
        endcase
      end
      m_seff = o_skip;
      m_heff = o_halt;
    end
    if (ewr[0]) m_skip = ewd[0];
    if (ewr[1]) m_halt = ewd[1];
    if (pe && o_heff) m_halted = 1;
    @(posedge clk);
    exp_q.push_back({m_halted, m_halt, m_skip, pulse});
    req_q.push_back(req);
  endtask

  task automatic op(input logic [3:0] code, input logic [7:0] pin, input string req);
    step(1'b1, code, pin, 2'b00, 2'b00, 1'b0, req);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; instr_valid = 0; instr_code = 0; port_in = 0;
    flag_wr = 0; flag_wdata = 0; pass_end = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_now(11'b0, "R1 in reset");
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_now(11'b0, "R1 after release");

    // R1: no port selected reads 0; OUT gives nothing
    op(4'd4, 8'hFF, "R1 load unselected");
    op(4'd7, 8'hFF, "R1 invert");
    op(4'd6, 8'hFF, "R1 out unselected");
    // R2/R4: select port 3, load 1, pulse
    op(4'd10, 8'h04, "R2 select port3");
    op(4'd4,  8'h04, "R3 load");
    op(4'd6,  8'h04, "R4 pulse port3");
    op(4'd6,  8'h04, "R4 back-to-back pulse");
    op(4'd7,  8'h00, "R3 not");
    op(4'd6,  8'h00, "R4 zero acc no pulse");
    // R3: logic truth tables on port 5
    for (int o = 0; o < 3; o++) begin
      for (int ab = 0; ab < 4; ab++) begin
        logic [3:0] c;
        c = (o == 0) ? 4'd1 : (o == 1) ? 4'd3 : 4'd5;
        op(4'd12, {3'b000, ab[1], 4'b0000}, "R2 select port5");
        op(4'd4,  {3'b000, ab[1], 4'b0000}, "R3 load a");
        op(c,     {3'b000, ab[0], 4'b0000}, "R3 logic op");
        op(4'd6,  8'h00, "R3 result out");
      end
    end
    // R5: write SKIP via OUT, read back ignoring pin
    op(4'd10, 8'h04, "R2 select port3");
    op(4'd4,  8'h04, "R3 load one");
    op(4'd8,  8'h00, "R2 select port1");
    op(4'd6,  8'h00, "R5 write skip");
    // R8: SKZ one slot later still sees old SKIP
    op(4'd2,  8'h00, "R8 skz lagged");
    op(4'd6,  8'h00, "R8 out not skipped");
    // R7: now SKIP effective: drop next
    op(4'd2,  8'h00, "R7 skz armed");
    op(4'd6,  8'h00, "R7 out dropped");
    op(4'd6,  8'h00, "R7 only one dropped");
    op(4'd2,  8'h00, "R7 skz armed");
    op(4'd13, 8'h00, "R7 select dropped");
    op(4'd7,  8'h00, "R7 still port1");
    op(4'd4,  8'h00, "R5 load skip scratch");
    op(4'd6,  8'h00, "R5 flag reads 1 not pin");
    // R10: idle cycle with OUT code
    step(1'b0, 4'd6, 8'h00, 2'b00, 2'b00, 1'b0, "R10 invalid ignored");
    op(4'd0, 8'h00, "R10 code zero");
    // R6: external clear beats OUT
    step(1'b1, 4'd6, 8'h00, 2'b01, 2'b00, 1'b0, "R6 ext wins");
    step(1'b0, 4'd0, 8'h00, 2'b01, 2'b01, 1'b0, "R6 ext set");
    op(4'd2,  8'h00, "R7 skz off lag");
    op(4'd0,  8'h00, "R7 slot");
    step(1'b0, 4'd0, 8'h00, 2'b01, 2'b00, 1'b0, "R6 ext clear");
    op(4'd0,  8'h00, "R8 slot");
    op(4'd2,  8'h00, "R7 skz zero no drop");
    op(4'd6,  8'h00, "R7 executes");

    // random stream, no pass end
    for (int i = 0; i < 400; i++) begin
      logic [1:0] w;
      w = ($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'b00;
      step(1'($urandom_range(0, 5) != 0), 4'($urandom), 8'($urandom), w,
           2'($urandom), 1'b0, "R3 R7 random");
    end

    // R9: halt
    step(1'b0, 4'd0, 8'h00, 2'b11, 2'b00, 1'b0, "R6 clear flags");
    op(4'd0,  8'h00, "R8 slot");
    op(4'd0,  8'h00, "R8 slot");
    op(4'd10, 8'h04, "R2 select port3");
    op(4'd4,  8'h04, "R3 load one");
    op(4'd9,  8'h00, "R2 select port2");
    op(4'd6,  8'h00, "R5 write halt");
    step(1'b0, 4'd0, 8'h00, 2'b00, 2'b00, 1'b1, "R8 halt lagged");
    op(4'd0,  8'h00, "R8 slot");
    step(1'b0, 4'd0, 8'h00, 2'b00, 2'b00, 1'b1, "R9 halt taken");
    op(4'd10, 8'h04, "R9 ignored select");
    op(4'd6,  8'h00, "R9 ignored out");
    step(1'b0, 4'd0, 8'h00, 2'b10, 2'b00, 1'b0, "R9 sticky");
    op(4'd6,  8'h00, "R9 still halted");

    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_now(11'b0, "R1 reset clears halt");
    done = 1'b1;
    finish_run();
  end
endmodule